// File: doc/BRIEF.md
# Guest Timer Compare Unit

This block keeps a 64-bit compare value for a guest's supervisor timer and raises the guest timer-pending bit once the guest's view of time reaches it. The guest's view of time is the platform time plus a 64-bit offset programmed by the hypervisor. The sum wraps modulo 2^64. The pending bit the hypervisor sees is the OR of two terms: a pending bit the hypervisor injects itself, and the compare result. The compare result counts only while two enables are both set. The machine-level enable is an input. The hypervisor-level enable is a bit held inside this block, and it is forced to zero whenever the machine-level enable is off.

Software reaches the compare value through a CSR-style port. With a 64-bit register width, one address holds the whole value. With a 32-bit register width, the low half and the high half sit at two addresses, 0x24D and 0x25D, so a surrounding CSR decoder can keep those numbers. The pending output is registered, and the state of the virtualization mode has no effect on it.

Top module: `vtimer_cmp_unit`

## Requirements
- R1: After reset the compare register holds all ones, and reading address 0x24D returns its low XLEN bits.
- R2: With XLEN=32, a write to 0x24D changes only bits 31:0 and a write to 0x25D changes only bits 63:32, and reads of those addresses return the same halves. With XLEN=64, 0x24D reaches all 64 bits, while 0x25D reads 0 and writes to it are ignored. Without a write strobe the register does not change.
- R3: A write to any other address leaves the compare register unchanged, and a read of any other address returns 0.
- R4: The compare term is true when ((time + offset) mod 2^64) >= compare, taken as unsigned values, so a sum that wraps past 2^64 becomes small again.
- R5: The pending output is a register stage. It shows injected OR (compare term AND both enables) as sampled at the previous clock edge, so a compare write becomes visible two edges after it is issued.
- R6: While the machine-level enable is 0, the pending output equals the injected bit of the previous cycle.
- R7: The hypervisor-level enable reads 0 and cannot be set while the machine-level enable is 0. A clock edge with the machine enable at 0 clears it. With the machine enable at 1, a write stores the written value.
- R8: While the hypervisor-level enable is 0, the pending output equals the injected bit of the previous cycle.
- R9: After reset the pending output is 0 and the hypervisor-level enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for the read and the write |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational on the address) |
| hyp_en_we_i | input | 1 | Write strobe for the hypervisor-level enable |
| hyp_en_wdata_i | input | 1 | Value to store in the hypervisor-level enable |
| hyp_en_o | output | 1 | Read value of the hypervisor-level enable |
| mach_en_i | input | 1 | Machine-level enable |
| time_i | input | CMP_W | Platform time |
| delta_i | input | CMP_W | Guest time offset |
| inj_pend_i | input | 1 | Pending bit injected by the hypervisor |
| vpend_o | output | 1 | Combined guest timer pending bit |

## Verification
The bench builds two copies of the block. The main copy uses XLEN=32 and exercises the split-half addressing, the gating, the latency and the wrapped compare. The second copy uses XLEN=64 and reaches the single-address layout, where the high address reads zero and ignores writes. Both copies keep CMP_W=64, so the wrap case needs a time close to 2^64 plus a small offset, and that sum lands below a small compare value.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

   typedef enum logic [1:0] {
      VTC_SEL_NONE = 2'd0,
      VTC_SEL_LO   = 2'd1,
      VTC_SEL_HI   = 2'd2
   } vtc_sel_e;

   localparam int unsigned VTC_ADDR_W = 12;

   typedef logic [VTC_ADDR_W-1:0] vtc_addr_t;

endpackage

// File: rtl/vtc_addr_dec.sv
module vtc_addr_dec
   import vtc_pkg::*;
#(
   parameter vtc_addr_t ADDR_LO = 12'h24D,
   parameter vtc_addr_t ADDR_HI = 12'h25D
) (
   input  vtc_addr_t addr_i,
   output vtc_sel_e  sel_o
);

   always_comb begin
      if (addr_i == ADDR_LO)      sel_o = VTC_SEL_LO;
      else if (addr_i == ADDR_HI) sel_o = VTC_SEL_HI;
      else                        sel_o = VTC_SEL_NONE;
   end

endmodule

// File: rtl/vtc_cmp_reg.sv
module vtc_cmp_reg
   import vtc_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned CMP_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  vtc_sel_e         sel_i,
   input  logic [XLEN-1:0]  wdata_i,
   output logic [XLEN-1:0]  rdata_o,
   output logic [CMP_W-1:0] cmp_o
);

   localparam int unsigned NWORDS = CMP_W / XLEN;

   logic [CMP_W-1:0] cmp_q;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam vtc_sel_e WSEL = (w == 0) ? VTC_SEL_LO : VTC_SEL_HI;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            cmp_q[w*XLEN +: XLEN] <= '1;
         else if (we_i && sel_i == WSEL)
            cmp_q[w*XLEN +: XLEN] <= wdata_i;
      end
   end

   if (NWORDS == 2) begin : g_split_rd
      always_comb begin
         unique case (sel_i)
            VTC_SEL_LO: rdata_o = cmp_q[XLEN-1:0];
            VTC_SEL_HI: rdata_o = cmp_q[CMP_W-1:XLEN];
            default:    rdata_o = '0;
         endcase
      end
   end else begin : g_full_rd
      always_comb begin
         rdata_o = (sel_i == VTC_SEL_LO) ? cmp_q : '0;
      end
   end

   assign cmp_o = cmp_q;

endmodule

// File: rtl/vtc_hyp_en.sv
module vtc_hyp_en (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mach_en_i,
   input  logic we_i,
   input  logic wdata_i,
   output logic en_o
);

   logic en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         en_q <= 1'b0;
      else if (!mach_en_i) en_q <= 1'b0;
      else if (we_i)       en_q <= wdata_i;
   end

   assign en_o = en_q;

endmodule

// File: rtl/vtc_pend_stage.sv
module vtc_pend_stage #(
   parameter int unsigned CMP_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CMP_W-1:0] time_i,
   input  logic [CMP_W-1:0] delta_i,
   input  logic [CMP_W-1:0] cmp_i,
   input  logic             gate_i,
   input  logic             inj_i,
   output logic             pend_o
);

   logic [CMP_W-1:0] guest_time;
   logic             hit;
   logic             pend_q;

   always_comb begin
      guest_time = time_i + delta_i;
      hit        = (guest_time >= cmp_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= inj_i | (hit & gate_i);
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/vtimer_cmp_unit.sv
module vtimer_cmp_unit
   import vtc_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CMP_W   = 64,
   parameter vtc_addr_t   ADDR_LO = 12'h24D,
   parameter vtc_addr_t   ADDR_HI = 12'h25D
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             csr_we_i,
   input  logic [11:0]      csr_addr_i,
   input  logic [XLEN-1:0]  csr_wdata_i,
   output logic [XLEN-1:0]  csr_rdata_o,
   input  logic             hyp_en_we_i,
   input  logic             hyp_en_wdata_i,
   output logic             hyp_en_o,
   input  logic             mach_en_i,
   input  logic [CMP_W-1:0] time_i,
   input  logic [CMP_W-1:0] delta_i,
   input  logic             inj_pend_i,
   output logic             vpend_o
);

   localparam int unsigned NWORDS = CMP_W / XLEN;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("vtimer_cmp_unit: XLEN must be 32 or 64");
   end
   if (NWORDS * XLEN != CMP_W || NWORDS < 1 || NWORDS > 2) begin : g_bad_cmpw
      $error("vtimer_cmp_unit: CMP_W must be one or two XLEN words");
   end
   if (ADDR_LO == ADDR_HI) begin : g_bad_addr
      $error("vtimer_cmp_unit: the two addresses must differ");
   end

   vtc_sel_e         sel;
   logic [CMP_W-1:0] cmp_val;
   logic             hyp_en;

   vtc_addr_dec #(
      .ADDR_LO (ADDR_LO),
      .ADDR_HI (ADDR_HI)
   ) u_dec (
      .addr_i (csr_addr_i),
      .sel_o  (sel)
   );

   vtc_cmp_reg #(
      .XLEN  (XLEN),
      .CMP_W (CMP_W)
   ) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (csr_we_i),
      .sel_i   (sel),
      .wdata_i (csr_wdata_i),
      .rdata_o (csr_rdata_o),
      .cmp_o   (cmp_val)
   );

   vtc_hyp_en u_hen (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mach_en_i (mach_en_i),
      .we_i      (hyp_en_we_i),
      .wdata_i   (hyp_en_wdata_i),
      .en_o      (hyp_en)
   );

   vtc_pend_stage #(
      .CMP_W (CMP_W)
   ) u_pend (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .time_i  (time_i),
      .delta_i (delta_i),
      .cmp_i   (cmp_val),
      .gate_i  (mach_en_i & hyp_en),
      .inj_i   (inj_pend_i),
      .pend_o  (vpend_o)
   );

   assign hyp_en_o = hyp_en;

endmodule

// File: rtl/vtimer_cmp_unit_chk.sv
module vtimer_cmp_unit_chk #(
   parameter int unsigned CMP_W = 64
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             csr_we_i,
   input logic             mach_en_i,
   input logic             hyp_en_o,
   input logic             inj_pend_i,
   input logic             vpend_o,
   input logic [CMP_W-1:0] time_i,
   input logic [CMP_W-1:0] delta_i,
   input logic [CMP_W-1:0] cmp_val
);

   logic [CMP_W-1:0] g_time;
   assign g_time = time_i + delta_i;

   assert_inj_reaches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inj_pend_i |=> vpend_o);

   assert_mach_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mach_en_i |=> (vpend_o == $past(inj_pend_i)));

   assert_hyp_forced_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mach_en_i |=> !hyp_en_o);

   assert_hyp_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hyp_en_o |=> (vpend_o == $past(inj_pend_i)));

   assert_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mach_en_i && hyp_en_o && (g_time >= cmp_val)) |=> vpend_o);

   assert_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inj_pend_i && (g_time < cmp_val)) |=> !vpend_o);

   assert_cmp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !csr_we_i |=> $stable(cmp_val));

endmodule

bind vtimer_cmp_unit vtimer_cmp_unit_chk #(.CMP_W(CMP_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .csr_we_i   (csr_we_i),
   .mach_en_i  (mach_en_i),
   .hyp_en_o   (hyp_en_o),
   .inj_pend_i (inj_pend_i),
   .vpend_o    (vpend_o),
   .time_i     (time_i),
   .delta_i    (delta_i),
   .cmp_val    (cmp_val)
);

// File: tb/vtimer_cmp_unit_bench.sv
module vtimer_cmp_unit_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = 12'h000;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        hwe = 1'b0;
   logic        hwd = 1'b0;
   logic        hen;
   logic        mach = 1'b0;
   logic [63:0] tm = '0;
   logic [63:0] dl = '0;
   logic        inj = 1'b0;
   logic        pend;

   logic        w_we = 1'b0;
   logic [11:0] w_addr = 12'h000;
   logic [63:0] w_wdata = '0;
   logic [63:0] w_rdata;
   logic        w_hen;
   logic        w_pend;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   vtimer_cmp_unit #(.XLEN(32), .CMP_W(64)) u_vtimer_cmp_unit (
      .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
      .csr_wdata_i(wdata), .csr_rdata_o(rdata), .hyp_en_we_i(hwe),
      .hyp_en_wdata_i(hwd), .hyp_en_o(hen), .mach_en_i(mach), .time_i(tm),
      .delta_i(dl), .inj_pend_i(inj), .vpend_o(pend));

   vtimer_cmp_unit #(.XLEN(64), .CMP_W(64)) u_vtimer_cmp_unit_x64 (
      .clk_i(clk), .rst_ni(rst_n), .csr_we_i(w_we), .csr_addr_i(w_addr),
      .csr_wdata_i(w_wdata), .csr_rdata_o(w_rdata), .hyp_en_we_i(1'b0),
      .hyp_en_wdata_i(1'b0), .hyp_en_o(w_hen), .mach_en_i(mach), .time_i(tm),
      .delta_i(dl), .inj_pend_i(inj), .vpend_o(w_pend));

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic hyp_wr(input logic v);
      @(negedge clk);
      hwe = 1'b1; hwd = v;
      @(negedge clk);
      hwe = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      csr_rd(12'h24D, d);
      chk("R1", "reset low half", {32'h0, d}, 64'hFFFF_FFFF);
      csr_rd(12'h25D, d);
      chk("R1", "reset high half", {32'h0, d}, 64'hFFFF_FFFF);
      chk("R9", "reset pending", {63'h0, pend}, 64'h0);
      chk("R9", "reset hyp enable", {63'h0, hen}, 64'h0);
   endtask

   task automatic t_split();
      logic [31:0] d;
      csr_wr(12'h24D, 32'h1234_5678);
      csr_rd(12'h24D, d);
      chk("R2", "low half after low write", {32'h0, d}, 64'h1234_5678);
      csr_rd(12'h25D, d);
      chk("R2", "high half after low write", {32'h0, d}, 64'hFFFF_FFFF);
      csr_wr(12'h25D, 32'h0000_00A5);
      csr_rd(12'h25D, d);
      chk("R2", "high half after high write", {32'h0, d}, 64'hA5);
      csr_rd(12'h24D, d);
      chk("R2", "low half after high write", {32'h0, d}, 64'h1234_5678);
   endtask

   task automatic t_other();
      logic [31:0] d;
      csr_wr(12'h14D, 32'hDEAD_BEEF);
      csr_rd(12'h24D, d);
      chk("R3", "low half after foreign write", {32'h0, d}, 64'h1234_5678);
      csr_rd(12'h25D, d);
      chk("R3", "high half after foreign write", {32'h0, d}, 64'hA5);
      csr_rd(12'h14D, d);
      chk("R3", "foreign read", {32'h0, d}, 64'h0);
   endtask

   task automatic t_enable();
      mach = 1'b0;
      hyp_wr(1'b1);
      chk("R7", "hyp enable set while machine off", {63'h0, hen}, 64'h0);
      mach = 1'b1;
      hyp_wr(1'b1);
      chk("R7", "hyp enable set while machine on", {63'h0, hen}, 64'h1);
   endtask

   task automatic t_compare();
      csr_wr(12'h24D, 32'h0);
      csr_wr(12'h25D, 32'h1);
      tm = 64'hFFFF_FFFF; dl = 64'h0;
      step();
      chk("R4", "one below compare", {63'h0, pend}, 64'h0);
      tm = 64'h1_0000_0000;
      step();
      chk("R4", "equal to compare", {63'h0, pend}, 64'h1);
      tm = 64'h8000_0000; dl = 64'h8000_0000;
      step();
      chk("R4", "offset reaches compare", {63'h0, pend}, 64'h1);
      dl = 64'h7FFF_FFFF;
      step();
      chk("R4", "offset one short", {63'h0, pend}, 64'h0);
      dl = 64'h8000_0001;
      step();
      chk("R4", "offset above compare", {63'h0, pend}, 64'h1);
      csr_wr(12'h25D, 32'h2);
      chk("R5", "pending one edge after compare write", {63'h0, pend}, 64'h1);
      step();
      chk("R5", "pending two edges after compare write", {63'h0, pend}, 64'h0);
   endtask

   task automatic t_wrap();
      csr_wr(12'h25D, 32'h0);
      csr_wr(12'h24D, 32'h10);
      tm = 64'hFFFF_FFFF_FFFF_FFF8; dl = 64'h10;
      step();
      chk("R4", "wrapped sum below compare", {63'h0, pend}, 64'h0);
      dl = 64'h18;
      step();
      chk("R4", "wrapped sum equal compare", {63'h0, pend}, 64'h1);
      dl = 64'h17;
      step();
      chk("R4", "wrapped sum one short", {63'h0, pend}, 64'h0);
      dl = 64'h0;
      step();
      chk("R4", "unwrapped large time", {63'h0, pend}, 64'h1);
   endtask

   task automatic t_gate();
      dl = 64'h18;
      step();
      chk("R5", "hit with both enables", {63'h0, pend}, 64'h1);
      mach = 1'b0;
      step();
      chk("R6", "machine off drops compare", {63'h0, pend}, 64'h0);
      chk("R7", "machine off clears hyp enable", {63'h0, hen}, 64'h0);
      inj = 1'b1;
      step();
      chk("R6", "machine off keeps injected", {63'h0, pend}, 64'h1);
      inj = 1'b0; mach = 1'b1;
      step();
      chk("R7", "hyp enable stays clear", {63'h0, hen}, 64'h0);
      chk("R8", "hyp off drops compare", {63'h0, pend}, 64'h0);
      inj = 1'b1;
      step();
      chk("R8", "hyp off keeps injected", {63'h0, pend}, 64'h1);
      inj = 1'b0;
      hyp_wr(1'b1);
      chk("R5", "one edge after enable write", {63'h0, pend}, 64'h0);
      step();
      chk("R8", "compare restored", {63'h0, pend}, 64'h1);
      inj = 1'b1;
      dl = 64'h0; tm = 64'h0;
      step();
      chk("R5", "injected with no hit", {63'h0, pend}, 64'h1);
      inj = 1'b0;
      step();
      chk("R5", "no injected no hit", {63'h0, pend}, 64'h0);
   endtask

   task automatic t_wide();
      w_addr = 12'h24D;
      #1;
      chk("R1", "wide reset value", w_rdata, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      w_we = 1'b1; w_addr = 12'h24D; w_wdata = 64'h0123_4567_89AB_CDEF;
      @(negedge clk);
      w_we = 1'b1; w_addr = 12'h25D; w_wdata = 64'h5555_5555_5555_5555;
      @(negedge clk);
      w_we = 1'b0;
      w_addr = 12'h24D;
      #1;
      chk("R2", "wide full write kept", w_rdata, 64'h0123_4567_89AB_CDEF);
      w_addr = 12'h25D;
      #1;
      chk("R2", "wide high address reads zero", w_rdata, 64'h0);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_split();
      t_other();
      t_enable();
      t_compare();
      t_wrap();
      t_gate();
      t_wide();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule